// File: doc/BRIEF.md
# Indexed ARX Round Sequencer

This block carries out one full ChaCha-style double round on a sixteen-word state of 32-bit words. The state sits in registers inside the block. A single add-xor-rotate datapath is shared by all the work, so each clock commits one sub-step and the whole round takes 32 cycles. The wiring does not fix which words a sub-step touches. Each sub-step reads three word indices from three programmable lookup tables, one per operand. It reads its rotate distance from a fixed four-entry amount list, selected through a small loadable permutation table.

A step counter drives the lookups. A start pulse loads the counter with the sub-step count, and the counter falls by one per commit. When reset releases, the operand tables hold the usual four-columns-then-four-diagonals schedule and the permutation is the identity, so the block computes a standard double round without any programming. Software loads the state and, if it wishes, new tables through one write port. It then pulses start, waits for the done pulse and reads the words back through a combinational read port.

Top module: `arx_round_seq`

## Requirements
- R1: After reset, busy, done and step_cnt are 0 and every state word reads 0.
- R2: A sub-step with operand indices (p, q, r) and rotate amount n first sets word p to p + q mod 2^32, then sets word r to r XOR the new word p, then rotates word r left by n.
- R3: Sub-step k (k = 32 - step_cnt while busy) takes p, q and r from entry k of the first, second and third operand tables. Only the low 4 bits of a written entry are kept. After reset the tables hold, for quarter groups (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15), (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14) taken in that order as (a,b,c,d), the four sub-steps (a,b,d), (c,d,b), (a,b,d), (c,d,b).
- R4: The rotate amount of sub-step k is entry perm[k mod 4] of the list {16, 12, 8, 7} at positions 0 to 3, reduced to its low 5 bits. After reset perm is the identity.
- R5: A start pulse while idle loads step_cnt with 32 on the next edge. step_cnt then falls by one per sub-step, busy stays high for exactly 32 cycles, and step_cnt then reads 0 and stays 0 until the next start.
- R6: done is high for exactly one cycle, the cycle after the last sub-step commits. In that cycle busy is 0 and step_cnt is 0.
- R7: A start pulse that arrives while busy is 1 has no effect. The run still ends after 32 sub-steps and no new run follows.
- R8: A write (wr_en = 1) goes to the state when wr_tgt = 0, to the first, second or third operand table when wr_tgt = 1, 2 or 3, and to the permutation table when wr_tgt = 4. Writes while busy are ignored. A write and a start in the same idle cycle both take effect, and the run uses the written value.
- R9: Tables programmed with other indices and another permutation produce the result of that schedule.
- R10: When p equals r in a sub-step, the XOR uses the freshly added value of word p, and the rotated result is what word p holds afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, honoured only while idle |
| wr_tgt | input | 3 | Write target: 0 state, 1..3 operand tables, 4 permutation |
| wr_addr | input | 5 | Word index, table entry or permutation slot |
| wr_data | input | 32 | Write data; tables keep the low bits |
| start | input | 1 | Start pulse for one double round |
| rd_addr | input | 4 | State word to read |
| rd_data | output | 32 | Selected state word, combinational |
| busy | output | 1 | High while sub-steps are running |
| done | output | 1 | One-cycle completion pulse |
| step_cnt | output | 6 | Remaining sub-steps |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a start pulse and the final sub-step commit. The bench holds start high through the last busy cycle and through the cycle in the middle of the run. It judges the result by a done pulse that still arrives after exactly 32 cycles, by busy staying low afterwards, and by words that match a behavioural model. The second pair is a state write and a start in the same idle cycle. The bench judges that case by a model run that includes the written word, while a write made during the run must leave no trace in the words read back.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam logic [2:0] TGT_STATE = 3'd0;
    localparam logic [2:0] TGT_PERM  = 3'd4;

    // Default entry k of table kind: 0..2 operand index, 3 rotate permutation
    function automatic int sched_default(input int kind, input int k);
        int grp, sub, dg, a, b, c, d, v;
        grp = k / 4;
        sub = k % 4;
        if (grp < 4) begin
            a = grp; b = grp + 4; c = grp + 8; d = grp + 12;
        end else begin
            dg = grp - 4;
            a = dg;
            b = 4 + ((dg + 1) % 4);
            c = 8 + ((dg + 2) % 4);
            d = 12 + ((dg + 3) % 4);
        end
        case (kind)
            0:       v = (sub % 2 == 0) ? a : c;
            1:       v = (sub % 2 == 0) ? b : d;
            2:       v = (sub % 2 == 0) ? d : b;
            default: v = k % 4;
        endcase
        return v;
    endfunction

    // Fixed rotate distance list
    function automatic int rot_base(input int slot);
        case (slot)
            0:       return 16;
            1:       return 12;
            2:       return 8;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/arx_table.sv
module arx_table #(
    parameter int KIND    = 0,
    parameter int DEPTH   = 32,
    parameter int ENTRY_W = 4,
    parameter int IDX_W   = 5,
    parameter int WA_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [WA_W-1:0]    waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [IDX_W-1:0]   raddr,
    output logic [ENTRY_W-1:0] rdata
);
    import arx_pkg::*;

    logic [DEPTH-1:0][ENTRY_W-1:0] tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (we && (int'(waddr) < DEPTH)) begin
            tab_d[waddr[IDX_W-1:0]] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                tab_q[k] <= ENTRY_W'(sched_default(KIND, k));
            end
        end else begin
            tab_q <= tab_d;
        end
    end

    assign rdata = tab_q[raddr];

endmodule

// File: rtl/arx_step_unit.sv
module arx_step_unit #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 16,
    parameter int SEL_W     = $clog2(NUM_WORDS),
    parameter int ROT_W     = $clog2(WORD_W)
) (
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] words_i,
    input  logic [SEL_W-1:0]                 sel_p,
    input  logic [SEL_W-1:0]                 sel_q,
    input  logic [SEL_W-1:0]                 sel_r,
    input  logic [ROT_W-1:0]                 rot_amt,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] words_o
);
    logic [WORD_W-1:0] sum_v, r_in, mix_v, rot_v;

    always_comb begin
        sum_v = words_i[sel_p] + words_i[sel_q];
        // r sees the updated p when both select the same word
        r_in  = (sel_r == sel_p) ? sum_v : words_i[sel_r];
        mix_v = r_in ^ sum_v;
        rot_v = (mix_v << rot_amt) | (mix_v >> (WORD_W - int'(rot_amt)));
        words_o = words_i;
        words_o[sel_p] = sum_v;
        words_o[sel_r] = rot_v;
    end

endmodule

// File: rtl/arx_round_seq.sv
module arx_round_seq #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 16,
    parameter int NUM_STEPS = 32,
    parameter int NUM_ROT   = 4,
    localparam int SEL_W    = $clog2(NUM_WORDS),
    localparam int STEP_W   = $clog2(NUM_STEPS),
    localparam int CNT_W    = $clog2(NUM_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_tgt,
    input  logic [STEP_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              start,
    input  logic [SEL_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  step_cnt
);
    import arx_pkg::*;

    localparam int PERM_W = $clog2(NUM_ROT);
    localparam int ROT_W  = $clog2(WORD_W);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] words;
        logic [CNT_W-1:0]                 cnt;
        logic                             done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic                             run_q;
    logic [STEP_W-1:0]                step_k;
    logic [2:0]                       tab_we;
    logic [SEL_W-1:0]                 op_idx [3];
    logic                             perm_we;
    logic [PERM_W-1:0]                perm_slot;
    logic [ROT_W-1:0]                 rot_amt;
    logic [NUM_WORDS-1:0][WORD_W-1:0] step_words;

    assign run_q  = (seq_q.cnt != '0);
    assign step_k = STEP_W'(NUM_STEPS - int'(seq_q.cnt));

    for (genvar t = 0; t < 3; t++) begin : g_op
        assign tab_we[t] = wr_en && !run_q && (wr_tgt == 3'(t + 1));
        arx_table #(
            .KIND(t), .DEPTH(NUM_STEPS), .ENTRY_W(SEL_W),
            .IDX_W(STEP_W), .WA_W(STEP_W)
        ) u_tab (
            .clk(clk), .rst_n(rst_n), .we(tab_we[t]), .waddr(wr_addr),
            .wdata(wr_data[SEL_W-1:0]), .raddr(step_k), .rdata(op_idx[t])
        );
    end

    assign perm_we = wr_en && !run_q && (wr_tgt == TGT_PERM);

    arx_table #(
        .KIND(3), .DEPTH(NUM_ROT), .ENTRY_W(PERM_W),
        .IDX_W(PERM_W), .WA_W(STEP_W)
    ) u_perm (
        .clk(clk), .rst_n(rst_n), .we(perm_we), .waddr(wr_addr),
        .wdata(wr_data[PERM_W-1:0]), .raddr(step_k[PERM_W-1:0]),
        .rdata(perm_slot)
    );

    assign rot_amt = ROT_W'(rot_base(int'(perm_slot)));

    arx_step_unit #(
        .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)
    ) u_step (
        .words_i(seq_q.words), .sel_p(op_idx[0]), .sel_q(op_idx[1]),
        .sel_r(op_idx[2]), .rot_amt(rot_amt), .words_o(step_words)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (run_q) begin
            seq_d.words = step_words;
            seq_d.cnt   = seq_q.cnt - 1'b1;
            seq_d.done  = (seq_q.cnt == CNT_W'(1));
        end else begin
            if (wr_en && (wr_tgt == TGT_STATE) && (int'(wr_addr) < NUM_WORDS)) begin
                seq_d.words[wr_addr[SEL_W-1:0]] = wr_data;
            end
            if (start) begin
                seq_d.cnt = CNT_W'(NUM_STEPS);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_data  = seq_q.words[rd_addr];
    assign busy     = run_q;
    assign done     = seq_q.done;
    assign step_cnt = seq_q.cnt;

endmodule

// File: rtl/arx_round_seq_chk.sv
module arx_round_seq_chk #(
    parameter int CNT_W     = 6,
    parameter int NUM_STEPS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] step_cnt
);
    p_start_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (step_cnt == CNT_W'(NUM_STEPS)));

    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (step_cnt == $past(step_cnt) - 1'b1));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (step_cnt == '0));

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && step_cnt == CNT_W'(1)) |=> !busy);

    p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(step_cnt) == CNT_W'(1)));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind arx_round_seq arx_round_seq_chk #(
    .CNT_W(CNT_W), .NUM_STEPS(NUM_STEPS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .step_cnt(step_cnt)
);

// File: tb/arx_round_seq_tb.sv
`timescale 1ns/1ps
module arx_round_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_tgt = '0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        start = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy, done;
    logic [5:0]  step_cnt;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    arx_round_seq u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .done(done), .step_cnt(step_cnt)
    );

    localparam int QG [8][4] = '{
        '{0, 4, 8, 12}, '{1, 5, 9, 13}, '{2, 6, 10, 14}, '{3, 7, 11, 15},
        '{0, 5, 10, 15}, '{1, 6, 11, 12}, '{2, 7, 8, 13}, '{3, 4, 9, 14}
    };
    localparam int ROTS [4] = '{16, 12, 8, 7};
    // Vector table: word i = mul * i + add; expected from the model
    localparam logic [31:0] PAT_MUL [4] = '{32'd2, 32'h9e3779b9, 32'hffffffff, 32'd1};
    localparam logic [31:0] PAT_ADD [4] = '{32'd0, 32'h01234567, 32'hfffffff0, 32'h80000000};

    int ta [32], tb [32], tc [32], tp [4];
    logic [31:0] mw [16];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bench_defaults();
        for (int g = 0; g < 8; g++) begin
            ta[4*g]   = QG[g][0]; tb[4*g]   = QG[g][1]; tc[4*g]   = QG[g][3];
            ta[4*g+1] = QG[g][2]; tb[4*g+1] = QG[g][3]; tc[4*g+1] = QG[g][1];
            ta[4*g+2] = QG[g][0]; tb[4*g+2] = QG[g][1]; tc[4*g+2] = QG[g][3];
            ta[4*g+3] = QG[g][2]; tb[4*g+3] = QG[g][3]; tc[4*g+3] = QG[g][1];
        end
        for (int i = 0; i < 4; i++) tp[i] = i;
    endtask

    function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
        if (n == 0) return x;
        return (x << n) | (x >> (32 - n));
    endfunction

    task automatic model_run();
        for (int k = 0; k < 32; k++) begin
            int p, q, r, n;
            p = ta[k] & 15; q = tb[k] & 15; r = tc[k] & 15;
            n = ROTS[tp[k % 4]] & 31;
            mw[p] = mw[p] + mw[q];
            mw[r] = mw[r] ^ mw[p];
            mw[r] = rotl(mw[r], n);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bench_defaults();
        for (int i = 0; i < 16; i++) mw[i] = '0;
    endtask

    task automatic wr(input logic [2:0] tgt, input int addr, input logic [31:0] data);
        wr_en = 1'b1; wr_tgt = tgt; wr_addr = 5'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_pattern(input logic [31:0] mul, input logic [31:0] add);
        for (int i = 0; i < 16; i++) begin
            mw[i] = mul * 32'(i) + add;
            wr(3'd0, i, mw[i]);
        end
    endtask

    task automatic compare_words(input string tag);
        for (int i = 0; i < 16; i++) begin
            rd_addr = 4'(i);
            #0.1;
            check(tag, rd_data, mw[i]);
        end
    endtask

    // mode 0 plain, 1 start/write while busy, 2 write together with start
    task automatic run_round(input string tag, input int mode);
        int cycles;
        if (mode == 2) begin
            wr_en = 1'b1; wr_tgt = 3'd0; wr_addr = 5'd3; wr_data = 32'h5555aaaa;
            mw[3] = 32'h5555aaaa;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; wr_en = 1'b0;
        check({tag, " R5 busy after start"}, 32'(busy), 32'd1);
        check({tag, " R5 load"}, 32'(step_cnt), 32'd32);
        cycles = 0;
        while (!done && cycles < 100) begin
            start = (mode == 1) && (cycles == 10 || cycles == 31);
            wr_en = (mode == 1) && (cycles == 5 || cycles == 6);
            wr_tgt = (cycles == 5) ? 3'd0 : 3'd1;
            wr_addr = 5'd0;
            wr_data = 32'hdeadbeef;
            @(negedge clk);
            cycles++;
        end
        start = 1'b0; wr_en = 1'b0;
        check({tag, " R5 32 busy cycles"}, 32'(cycles), 32'd32);
        check({tag, " R6 busy low at done"}, 32'(busy), 32'd0);
        check({tag, " R5 counter zero"}, 32'(step_cnt), 32'd0);
        @(negedge clk);
        check({tag, " R6 done one cycle"}, 32'(done), 32'd0);
        check({tag, " R7 no restart"}, 32'(busy), 32'd0);
        model_run();
        compare_words({tag, " R2 words"});
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 step_cnt", 32'(step_cnt), 32'd0);
        compare_words("R1 state zero");

        // R2 R3 R4 default schedule over the vector table
        for (int v = 0; v < 4; v++) begin
            load_pattern(PAT_MUL[v], PAT_ADD[v]);
            run_round("R3 R4 default", 0);
        end

        // R7 R8 start and writes while busy, then write with start
        load_pattern(32'd3, 32'd7);
        run_round("R7 R8 busy inputs", 1);
        load_pattern(32'd5, 32'd11);
        run_round("R8 write with start", 2);

        // R9 R10 programmed tables with aliasing and upper bits set
        for (int k = 0; k < 32; k++) begin
            ta[k] = k % 16; tb[k] = (3 * k + 1) % 16; tc[k] = (5 * k) % 16;
            wr(3'd1, k, 32'h000000a0 | 32'(ta[k]));
            wr(3'd2, k, 32'h000000f0 | 32'(tb[k]));
            wr(3'd3, k, 32'(tc[k]));
        end
        tp = '{3, 1, 0, 2};
        for (int i = 0; i < 4; i++) wr(3'd4, i, 32'(tp[i]));
        load_pattern(32'h01010101, 32'h10203040);
        run_round("R9 R10 programmed", 0);

        // R3 reset restores default tables; word i = 2*i
        do_reset();
        load_pattern(32'd2, 32'd0);
        run_round("R3 defaults after reset", 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule